// File: doc/BRIEF.md
# Harmonic Spur Canceller

This block sits between the phase-to-amplitude stage of a direct digital synthesizer and the 14-bit converter that follows it. The converter's nonlinearity creates spurs at integer multiples of the synthesized frequency. The block builds a small sinusoid locked to a chosen multiple of the synthesizer phase and adds it to every sample. Its amplitude and phase are programmable, so the added tone can be set equal in size and opposite in phase to one such spur, and the two cancel at the converter output.

Each cycle the block takes the upper 16 bits of the phase accumulator, the signed sample and a configuration set: enable, harmonic number, 4-bit amplitude and a 16-bit phase offset. The tone phase is the accumulator phase times the harmonic number plus the offset. A quarter-wave sine table, mirrored into the other three quadrants, gives the tone value. The amplitude then scales it so that the correction never leaves the lowest four bits of the converter range. The sum with the sample is clipped to the 14-bit signed range. Configuration is captured together with the sample it applies to, and the result leaves the block exactly three cycles later with a matching valid flag.

Top module: `spur_cancel_top`

## Requirements
- R1: A clock edge with rst_n low (synchronous, active low) clears out_valid to 0 and out_sample to 0 from the following cycle on.
- R2: out_valid equals in_valid as it was sampled three rising edges earlier. out_sample follows the same three-cycle timing.
- R3: The tone phase is (cfg_harmonic × acc_phase + cfg_phase_off) mod 2^16, with the wrap taken modulo 2^16.
- R4: Tone phase bits [15:14] select the quadrant and bits [13:8] give a 6-bit index i. The table entry at position k holds floor(255·16·p / (327680 − 4p)), where p = (2k+1)(255 − 2k). Quadrants 0 and 2 read entry i and quadrants 1 and 3 read entry 63−i. Quadrants 2 and 3 negate the value.
- R5: The correction magnitude is floor(entry × cfg_amp / 256). It never exceeds 14, so it stays within the lowest 4 bits of the sample range.
- R6: While active, out_sample = in_sample + correction, where the correction is computed from the configuration captured with that same sample.
- R7: When cfg_enable is 0, cfg_amp is 0 or cfg_harmonic is 0, out_sample equals in_sample exactly.
- R8: Adding 0x8000 to cfg_phase_off, with all other inputs unchanged, yields exactly the negated correction.
- R9: The sum clips to +8191 and −8192 instead of wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_sample as carrying data |
| acc_phase | input | 16 | Upper 16 bits of the synthesizer phase accumulator |
| in_sample | input | 14 | Signed sample from the phase-to-amplitude stage |
| cfg_enable | input | 1 | Turns on spur correction |
| cfg_harmonic | input | 4 | Harmonic to cancel, 1 to 15; 0 bypasses |
| cfg_amp | input | 4 | Unsigned correction amplitude |
| cfg_phase_off | input | 16 | Phase offset added to the tone phase |
| out_valid | output | 1 | in_valid delayed by three cycles |
| out_sample | output | 14 | Corrected signed sample to the converter |

## Verification
The bench targets the quadrant folding in two places: at the top of quadrant 0 and at the start of quadrant 1. If the mirror were misplaced, a correction of 14 would become 0 or swap sign at these points. It checks that a 180-degree offset gives the exact negation, and that harmonic multiplication and offset addition wrap modulo 2^16. A design that kept carries above bit 15 would lose that symmetry and place the tone in the wrong quadrant. Samples at and next to both rails exercise clipping, since a wrapping adder would flip full-scale positive to a large negative value. It also checks that each of the three bypass conditions returns the sample bit-exact, and that a single valid pulse appears on exactly the third edge and not the second or fourth.

// File: rtl/spur_pkg.sv
// Shared widths and the quarter-wave sine generator for the spur canceller.
// Assumes the table depth is a power of two and that the magnitude fits in an int.
package spur_pkg;
    localparam int SAMPLE_W = 14;
    localparam int TPHASE_W = 16;
    localparam int HARM_W   = 4;
    localparam int AMP_W    = 4;
    localparam int LUT_AW   = 6;
    localparam int MAG_W    = 8;

    typedef enum logic [1:0] {
        QD_RISE    = 2'd0,
        QD_FALL    = 2'd1,
        QD_NRISE   = 2'd2,
        QD_NFALL   = 2'd3
    } quad_e;

    // Rational sine approximation, sampled at half-step offsets so mirroring is exact.
    function automatic int quarter_sine(input int idx, input int aw, input int mw);
        int half;
        int x;
        int p;
        int full;
        half = 4 << aw;
        x    = 2 * idx + 1;
        p    = x * (half - x);
        full = (1 << mw) - 1;
        return (full * 16 * p) / (5 * half * half - 4 * p);
    endfunction
endpackage

// File: rtl/spur_phase_gen.sv
// Stage 1: forms the harmonic tone phase and captures the sample and settings with it.
// Assumes the phase input is already the upper bits of the accumulator.
module spur_phase_gen #(
    parameter int TPW = spur_pkg::TPHASE_W,
    parameter int HW  = spur_pkg::HARM_W,
    parameter int SW  = spur_pkg::SAMPLE_W,
    parameter int AW  = spur_pkg::AMP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [TPW-1:0]       acc_phase,
    input  logic signed [SW-1:0] in_sample,
    input  logic                 cfg_enable,
    input  logic [HW-1:0]        cfg_harmonic,
    input  logic [AW-1:0]        cfg_amp,
    input  logic [TPW-1:0]       cfg_phase_off,
    output logic [TPW-1:0]       ph_q,
    output logic signed [SW-1:0] sample_q,
    output logic                 valid_q,
    output logic                 active_q,
    output logic [AW-1:0]        amp_q
);
    logic [TPW-1:0] ph_next;
    logic           active_next;

    // Harmonic multiply and offset add, both modulo 2^TPW.
    always_comb begin
        ph_next     = (TPW'(cfg_harmonic) * acc_phase) + cfg_phase_off;
        active_next = cfg_enable && (cfg_amp != '0) && (cfg_harmonic != '0);
    end

    // Register the phase together with the data it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            sample_q <= '0;
            valid_q  <= 1'b0;
            active_q <= 1'b0;
            amp_q    <= '0;
        end else begin
            ph_q     <= ph_next;
            sample_q <= in_sample;
            valid_q  <= in_valid;
            active_q <= active_next;
            amp_q    <= cfg_amp;
        end
    end
endmodule

// File: rtl/spur_sine_lut.sv
// Stage 2: folds the tone phase into a quarter-wave table and registers magnitude and sign.
// Assumes TPW >= LAW + 2; the table is computed from the package function.
module spur_sine_lut #(
    parameter int TPW = spur_pkg::TPHASE_W,
    parameter int SW  = spur_pkg::SAMPLE_W,
    parameter int AW  = spur_pkg::AMP_W,
    parameter int LAW = spur_pkg::LUT_AW,
    parameter int MW  = spur_pkg::MAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TPW-1:0]       ph,
    input  logic signed [SW-1:0] sample,
    input  logic                 valid,
    input  logic                 active,
    input  logic [AW-1:0]        amp,
    output logic [MW-1:0]        mag_q,
    output logic                 neg_q,
    output logic signed [SW-1:0] sample_q,
    output logic                 valid_q,
    output logic                 active_q,
    output logic [AW-1:0]        amp_q
);
    import spur_pkg::*;

    localparam int DEPTH = 1 << LAW;
    localparam int SH    = TPW - 2 - LAW;

    logic [MW-1:0]  rom [DEPTH];
    logic [LAW+1:0] top;
    logic [LAW-1:0] idx;
    logic [LAW-1:0] addr;
    quad_e          quad;
    logic           neg_next;

    // One table entry per generate step, fixed at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = MW'(quarter_sine(g, LAW, MW));
    end

    // Quadrant folding: mirror the index on falling quadrants, negate in the lower half.
    always_comb begin
        top      = (LAW + 2)'(ph >> SH);
        quad     = quad_e'(top[LAW+1:LAW]);
        idx      = top[LAW-1:0];
        addr     = ((quad == QD_FALL) || (quad == QD_NFALL)) ? ~idx : idx;
        neg_next = (quad == QD_NRISE) || (quad == QD_NFALL);
    end

    // Register the looked-up magnitude with its sign and the passed-through data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q    <= '0;
            neg_q    <= 1'b0;
            sample_q <= '0;
            valid_q  <= 1'b0;
            active_q <= 1'b0;
            amp_q    <= '0;
        end else begin
            mag_q    <= rom[addr];
            neg_q    <= neg_next;
            sample_q <= sample;
            valid_q  <= valid;
            active_q <= active;
            amp_q    <= amp;
        end
    end
endmodule

// File: rtl/spur_mix_sat.sv
// Stage 3: scales the tone by the amplitude, adds it to the sample and clips to range.
// Assumes MW + AW bits hold the product and the correction stays far below full scale.
module spur_mix_sat #(
    parameter int SW = spur_pkg::SAMPLE_W,
    parameter int AW = spur_pkg::AMP_W,
    parameter int MW = spur_pkg::MAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MW-1:0]        mag,
    input  logic                 neg,
    input  logic signed [SW-1:0] sample,
    input  logic                 valid,
    input  logic                 active,
    input  logic [AW-1:0]        amp,
    output logic signed [SW-1:0] out_sample,
    output logic                 out_valid
);
    localparam logic signed [SW:0] SMAX = (SW + 1)'((1 << (SW - 1)) - 1);
    localparam logic signed [SW:0] SMIN = -SMAX - (SW + 1)'(1);

    logic [MW+AW-1:0]        prod;
    logic [AW-1:0]           cmag;
    logic signed [SW:0]      corr;
    logic signed [SW:0]      sum;
    logic signed [SW-1:0]    clipped;

    // Scale, sign and add in one widened step, then clip instead of wrapping.
    always_comb begin
        prod = {{AW{1'b0}}, mag} * {{MW{1'b0}}, amp};
        cmag = AW'(prod >> MW);
        corr = (SW + 1)'($signed({1'b0, cmag}));
        if (neg) begin
            corr = -corr;
        end
        if (!active) begin
            corr = '0;
        end
        sum = (SW + 1)'(sample) + corr;
        if (sum > SMAX) begin
            clipped = SW'(SMAX);
        end else if (sum < SMIN) begin
            clipped = SW'(SMIN);
        end else begin
            clipped = SW'(sum);
        end
    end

    // Output register feeding the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_sample <= clipped;
            out_valid  <= valid;
        end
    end
endmodule

// File: rtl/spur_cancel_top.sv
// Harmonic spur canceller: three-stage pipeline adding a harmonic-locked, phase-shifted
// low-level tone to each sample. Assumes configuration is sampled with each sample.
module spur_cancel_top #(
    parameter int SW  = spur_pkg::SAMPLE_W,
    parameter int TPW = spur_pkg::TPHASE_W,
    parameter int HW  = spur_pkg::HARM_W,
    parameter int AW  = spur_pkg::AMP_W,
    parameter int LAW = spur_pkg::LUT_AW,
    parameter int MW  = spur_pkg::MAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [TPW-1:0]       acc_phase,
    input  logic signed [SW-1:0] in_sample,
    input  logic                 cfg_enable,
    input  logic [HW-1:0]        cfg_harmonic,
    input  logic [AW-1:0]        cfg_amp,
    input  logic [TPW-1:0]       cfg_phase_off,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_sample
);
    logic [TPW-1:0]       s1_ph;
    logic signed [SW-1:0] s1_sample;
    logic                 s1_valid;
    logic                 s1_active;
    logic [AW-1:0]        s1_amp;
    logic [MW-1:0]        s2_mag;
    logic                 s2_neg;
    logic signed [SW-1:0] s2_sample;
    logic                 s2_valid;
    logic                 s2_active;
    logic [AW-1:0]        s2_amp;

    spur_phase_gen #(.TPW(TPW), .HW(HW), .SW(SW), .AW(AW)) u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .acc_phase     (acc_phase),
        .in_sample     (in_sample),
        .cfg_enable    (cfg_enable),
        .cfg_harmonic  (cfg_harmonic),
        .cfg_amp       (cfg_amp),
        .cfg_phase_off (cfg_phase_off),
        .ph_q          (s1_ph),
        .sample_q      (s1_sample),
        .valid_q       (s1_valid),
        .active_q      (s1_active),
        .amp_q         (s1_amp)
    );

    spur_sine_lut #(.TPW(TPW), .SW(SW), .AW(AW), .LAW(LAW), .MW(MW)) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (s1_ph),
        .sample   (s1_sample),
        .valid    (s1_valid),
        .active   (s1_active),
        .amp      (s1_amp),
        .mag_q    (s2_mag),
        .neg_q    (s2_neg),
        .sample_q (s2_sample),
        .valid_q  (s2_valid),
        .active_q (s2_active),
        .amp_q    (s2_amp)
    );

    spur_mix_sat #(.SW(SW), .AW(AW), .MW(MW)) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .mag        (s2_mag),
        .neg        (s2_neg),
        .sample     (s2_sample),
        .valid      (s2_valid),
        .active     (s2_active),
        .amp        (s2_amp),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );
endmodule

// File: rtl/spur_cancel_chk.sv
// Port-level checker for the spur canceller, bound to the top module.
// Keeps its own three-deep history of inputs so no check reaches before reset.
module spur_cancel_chk #(
    parameter int SW  = spur_pkg::SAMPLE_W,
    parameter int TPW = spur_pkg::TPHASE_W,
    parameter int HW  = spur_pkg::HARM_W,
    parameter int AW  = spur_pkg::AMP_W,
    parameter int MW  = spur_pkg::MAG_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [SW-1:0] in_sample,
    input logic                 cfg_enable,
    input logic [HW-1:0]        cfg_harmonic,
    input logic [AW-1:0]        cfg_amp,
    input logic                 out_valid,
    input logic signed [SW-1:0] out_sample
);
    localparam int CMAX = (((1 << MW) - 1) * ((1 << AW) - 1)) >> MW;

    logic [1:0]            warm;
    logic                  vd [3];
    logic                  bd [3];
    logic signed [SW-1:0]  sd [3];
    logic signed [SW:0]    diff;

    // Input history and a saturating count of edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= '0;
            for (int k = 0; k < 3; k++) begin
                vd[k] <= 1'b0;
                bd[k] <= 1'b0;
                sd[k] <= '0;
            end
        end else begin
            if (warm != 2'd3) begin
                warm <= warm + 2'd1;
            end
            vd[0] <= in_valid;
            bd[0] <= !cfg_enable || (cfg_amp == '0) || (cfg_harmonic == '0);
            sd[0] <= in_sample;
            for (int k = 1; k < 3; k++) begin
                vd[k] <= vd[k-1];
                bd[k] <= bd[k-1];
                sd[k] <= sd[k-1];
            end
        end
    end

    // Difference between output and the sample it came from.
    always_comb diff = (SW + 1)'(out_sample) - (SW + 1)'(sd[2]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == vd[2]));

    // R7
    bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && bd[2]) |-> (out_sample == sd[2]));

    // R5
    corr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (diff <= (SW + 1)'(CMAX) && diff >= -(SW + 1)'(CMAX)));
endmodule

bind spur_cancel_top spur_cancel_chk #(
    .SW(SW), .TPW(TPW), .HW(HW), .AW(AW), .MW(MW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sample    (in_sample),
    .cfg_enable   (cfg_enable),
    .cfg_harmonic (cfg_harmonic),
    .cfg_amp      (cfg_amp),
    .out_valid    (out_valid),
    .out_sample   (out_sample)
);

// File: tb/sim_spur_cancel_top.sv
// Directed bench for the spur canceller: one task per scenario, each checking its results.
module sim_spur_cancel_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [15:0]       acc_phase = '0;
    logic signed [13:0] in_sample = '0;
    logic              cfg_enable = 1'b0;
    logic [3:0]        cfg_harmonic = '0;
    logic [3:0]        cfg_amp = '0;
    logic [15:0]       cfg_phase_off = '0;
    logic              out_valid;
    logic signed [13:0] out_sample;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spur_cancel_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_phase(acc_phase),
        .in_sample(in_sample), .cfg_enable(cfg_enable), .cfg_harmonic(cfg_harmonic),
        .cfg_amp(cfg_amp), .cfg_phase_off(cfg_phase_off),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    // Table entry from the requirement formula.
    function automatic int ref_entry(int k);
        int x = 2 * k + 1;
        int p = x * (256 - x);
        return (255 * 16 * p) / (327680 - 4 * p);
    endfunction

    // Signed correction for one configuration.
    function automatic int ref_corr(int h, int acc, int off, int amp);
        int ph = (h * acc + off) % 65536;
        int q = ph / 16384;
        int i = (ph / 256) % 64;
        int c;
        if (q == 1 || q == 3) i = 63 - i;
        c = (ref_entry(i) * amp) / 256;
        if (q >= 2) c = -c;
        return c;
    endfunction

    function automatic int clip14(int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Apply one sample with its settings and return the output three edges later.
    task automatic run_one(bit en, int h, int amp, int off, int acc, int smp, output int res);
        @(negedge clk);
        in_valid      = 1'b1;
        cfg_enable    = en;
        cfg_harmonic  = 4'(h);
        cfg_amp       = 4'(amp);
        cfg_phase_off = 16'(off);
        acc_phase     = 16'(acc);
        in_sample     = 14'(smp);
        repeat (3) @(posedge clk);
        @(negedge clk);
        res = int'(out_sample);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_sample = 14'sd1000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid in reset", int'(out_valid), 0);
        chk("R1", "sample in reset", int'(out_sample), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "valid after 1 edge", int'(out_valid), 0);
        @(negedge clk);
        chk("R2", "valid after 2 edges", int'(out_valid), 0);
        @(negedge clk);
        chk("R2", "valid after 3 edges", int'(out_valid), 1);
        @(negedge clk);
        chk("R2", "valid after 4 edges", int'(out_valid), 0);
    endtask

    task automatic t_bypass();
        int r;
        run_one(1'b0, 3, 15, 0, 16'h3F00, 1234, r);
        chk("R7", "enable low", r, 1234);
        run_one(1'b1, 1, 0, 0, 16'h3F00, -4000, r);
        chk("R7", "amplitude zero", r, -4000);
        run_one(1'b1, 0, 15, 16'h3F00, 16'h1234, 77, r);
        chk("R7", "harmonic zero", r, 77);
        run_one(1'b0, 1, 15, 0, 16'h3F00, 8191, r);
        chk("R7", "enable low at rail", r, 8191);
    endtask

    task automatic t_phase();
        int r;
        int h_l[6]   = '{1, 3, 5, 7, 11, 15};
        int acc_l[6] = '{16'h0123, 16'h1500, 16'h5A5A, 16'h9C40, 16'hE001, 16'h7777};
        int off_l[6] = '{0, 16'h1000, 16'h8000, 16'hC3C3, 16'h0042, 16'hFFFF};
        int amp_l[6] = '{15, 9, 4, 15, 12, 7};
        run_one(1'b1, 1, 15, 0, 16'h3F00, 0, r);
        chk("R4", "quadrant 0 top entry", r, 14);
        run_one(1'b1, 1, 15, 0, 16'h4000, 0, r);
        chk("R4", "quadrant 1 mirrored start", r, 14);
        run_one(1'b1, 1, 15, 0, 16'h7F00, 0, r);
        chk("R4", "quadrant 1 end near zero", r, 0);
        run_one(1'b1, 3, 15, 0, 16'h1500, 0, r);
        chk("R3", "harmonic 3 multiply", r, 14);
        run_one(1'b1, 1, 15, 16'h4F00, 16'hF000, 0, r);
        chk("R3", "offset wrap mod 2^16", r, 14);
        run_one(1'b1, 1, 8, 0, 16'h3F00, 0, r);
        chk("R5", "amplitude 8 scaling", r, 7);
        run_one(1'b1, 1, 1, 0, 16'h3F00, 0, r);
        chk("R5", "amplitude 1 truncates", r, 0);
        for (int k = 0; k < 6; k++) begin
            run_one(1'b1, h_l[k], amp_l[k], off_l[k], acc_l[k], 100 * k - 250, r);
            chk("R6", "model pattern", r,
                100 * k - 250 + ref_corr(h_l[k], acc_l[k], off_l[k], amp_l[k]));
        end
    endtask

    task automatic t_opposite();
        int a;
        int b;
        int h_l[4]   = '{1, 2, 9, 15};
        int acc_l[4] = '{16'h3F00, 16'h2222, 16'h0F0F, 16'hABCD};
        int off_l[4] = '{0, 16'h0100, 16'h7000, 16'h9000};
        run_one(1'b1, 1, 15, 16'h8000, 16'h3F00, 0, a);
        chk("R8", "half-turn offset at peak", a, -14);
        for (int k = 0; k < 4; k++) begin
            run_one(1'b1, h_l[k], 15, off_l[k], acc_l[k], 500, a);
            run_one(1'b1, h_l[k], 15, (off_l[k] + 16'h8000) % 65536, acc_l[k], 500, b);
            chk("R8", "negated correction", b - 500, -(a - 500));
        end
    endtask

    task automatic t_clip();
        int r;
        run_one(1'b1, 1, 15, 0, 16'h3F00, 8191, r);
        chk("R9", "positive rail holds", r, 8191);
        run_one(1'b1, 1, 15, 0, 16'h3F00, 8180, r);
        chk("R9", "clip above positive rail", r, clip14(8180 + 14));
        run_one(1'b1, 1, 15, 16'h8000, 16'h3F00, -8192, r);
        chk("R9", "negative rail holds", r, -8192);
        run_one(1'b1, 1, 15, 16'h8000, 16'h3F00, -8185, r);
        chk("R9", "clip below negative rail", r, -8192);
        run_one(1'b1, 1, 15, 16'h8000, 16'h3F00, 8191, r);
        chk("R9", "negative correction at positive rail", r, 8177);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_bypass();
        t_phase();
        t_opposite();
        t_clip();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule